// File: doc/BRIEF.md
# Double-Buffered Row-to-Column Transposer

This block sits between a wide memory read port and a set of narrow output ports. Every accepted input word packs several pixels side by side. The block stacks a fixed number of these words as rows in one storage bank. It then plays the bank back one column at a time, so that each output port receives one pixel per cycle. A per-pixel mask on the input decides which pixel lanes of a word are written. Lanes that are masked off keep whatever that bank position last held.

There are two storage banks that swap roles. One bank takes input rows while the other emits its columns, so filling and draining overlap. The block marks each cycle that carries a column with a valid strobe. On the cycle that carries the final column of a bank, it also raises a completion pulse to show that a whole window has been sent. If the filling bank is complete and the other bank is still draining, the input side is stalled with a ready signal until the two banks can swap.

Top module: `transpose_buffer`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1, and `col_valid` and `stencil_done` are 0. Both banks hold all-zero pixels. The first fill goes to bank A.
- R2: A word is accepted when `in_valid` and `in_ready` are both 1 at a clock edge. The k-th word accepted into a bank (k counted from 0) is row k of that bank. Its pixel in lane j, which is `in_data[j*W +: W]`, is sent out in column j (columns counted from 0) on port k, which is `col_data[k*W +: W]`.
- R3: An accepted pixel whose bit in `in_mask` is 0 is not written. That position of the bank keeps its previous value, which is zero after reset or the value from an earlier fill of the same bank.
- R4: `in_ready` is 0 from the edge that accepts the last row of a bank until the banks swap. A word offered while `in_ready` is 0 is ignored.
- R5: A swap happens on the first edge where the filling bank is complete and the draining bank is either idle or showing its last column. The cycle after a swap, `col_valid` is 1 and column 0 of the newly filled bank is on the output.
- R6: Each bank drains in exactly MEM_W/WORD_W consecutive cycles, columns 0 upward. If the next bank is complete by the time the last column is shown, its column 0 follows with no gap.
- R7: `stencil_done` is 1 exactly in the cycle that shows the last column of a bank, and in no other cycle.
- R8: The banks alternate. Right after a swap, `in_ready` is 1, and the freed bank accepts rows while the other bank drains.
- R9: A reset in the middle of a fill or a drain discards all buffered data. Later fills start again in bank A, and masked positions read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Filling bank can take a row |
| in_data | input | MEM_W | Packed input pixels, lane j at bits j*WORD_W |
| in_mask | input | MEM_W/WORD_W | Per-lane write enable |
| col_valid | output | 1 | Column on `col_data` is valid |
| col_data | output | OUT_PORTS*WORD_W | One pixel per output port, port k at bits k*WORD_W |
| stencil_done | output | 1 | Last column of a bank is being shown |

## Verification
The bound checker checks the handshake and sequencing rules on every cycle. It checks that ready drops after a bank's last row is accepted and stays low until a swap. It checks that a swap always starts a drain and frees the fill side. It checks that a drain keeps going until its completion pulse, that the pulse only comes with a valid column, and what the outputs read after reset. Only the bench scenarios can show pixel placement and masking. That covers where each lane lands in each column, which masked positions keep the older contents of the same bank, and that words offered while stalled never turn up in the output. The same holds for continuous back-to-back draining and for the data being cleared by a reset during a drain.

// File: rtl/tpose_pkg.sv
package tpose_pkg;

  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic bank_e other_bank(bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction

  // Index width that stays at least one bit for a count of one.
  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tpose_fill_ctrl.sv
module tpose_fill_ctrl #(
  parameter int ROWS = 4,
  localparam int RW = tpose_pkg::idx_width(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_fire,
  input  logic          swap,
  output logic [RW-1:0] row_idx,
  output logic          full
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_idx <= '0;
      full    <= 1'b0;
    end else if (swap) begin
      row_idx <= '0;
      full    <= 1'b0;
    end else if (wr_fire) begin
      if (row_idx == LAST_ROW) begin
        row_idx <= '0;
        full    <= 1'b1;
      end else begin
        row_idx <= row_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tpose_drain_ctrl.sv
module tpose_drain_ctrl #(
  parameter int COLS = 8,
  localparam int CW = tpose_pkg::idx_width(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swap,
  output logic          active,
  output logic [CW-1:0] col_idx,
  output logic          last
);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      col_idx <= '0;
    end else if (swap) begin
      active  <= 1'b1;
      col_idx <= '0;
    end else if (active) begin
      if (col_idx == LAST_COL) begin
        active  <= 1'b0;
        col_idx <= '0;
      end else begin
        col_idx <= col_idx + 1'b1;
      end
    end
  end

  assign last = active && (col_idx == LAST_COL);
endmodule

// File: rtl/tpose_bank.sv
module tpose_bank #(
  parameter int W    = 8,
  parameter int ROWS = 4,
  parameter int COLS = 8,
  localparam int RW = tpose_pkg::idx_width(ROWS),
  localparam int CW = tpose_pkg::idx_width(COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RW-1:0]     wr_row,
  input  logic [COLS*W-1:0] wr_data,
  input  logic [COLS-1:0]   wr_mask,
  input  logic [CW-1:0]     rd_col,
  output logic [ROWS*W-1:0] rd_data
);
  logic [W-1:0] mem [ROWS][COLS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem[r][c] <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < COLS; c++)
        if (wr_mask[c]) mem[wr_row][c] <= wr_data[c*W +: W];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_port
    assign rd_data[r*W +: W] = mem[r][rd_col];
  end
endmodule

// File: rtl/transpose_buffer.sv
module transpose_buffer #(
  parameter int WORD_W    = 8,
  parameter int MEM_W     = 64,
  parameter int OUT_PORTS = 4,
  localparam int PIX = MEM_W / WORD_W,
  localparam int RW  = tpose_pkg::idx_width(OUT_PORTS),
  localparam int CW  = tpose_pkg::idx_width(PIX)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [MEM_W-1:0]            in_data,
  input  logic [PIX-1:0]              in_mask,
  output logic                        col_valid,
  output logic [OUT_PORTS*WORD_W-1:0] col_data,
  output logic                        stencil_done
);
  import tpose_pkg::*;

  // Named internal events, also observed by the bound checker.
  logic          accept;
  logic          swap_evt;
  logic          fill_full;
  logic [RW-1:0] fill_row;
  logic          drain_active;
  logic          drain_last;
  logic [CW-1:0] drain_col;
  bank_e         fill_sel;
  bank_e         drain_sel;

  logic [OUT_PORTS*WORD_W-1:0] bank_rd [2];

  assign in_ready  = !fill_full;
  assign accept    = in_valid && in_ready;
  assign swap_evt  = fill_full && (!drain_active || drain_last);
  assign drain_sel = other_bank(fill_sel);

  always_ff @(posedge clk) begin
    if (rst)           fill_sel <= BANK_A;
    else if (swap_evt) fill_sel <= other_bank(fill_sel);
  end

  tpose_fill_ctrl #(.ROWS(OUT_PORTS)) u_fill (
    .clk(clk), .rst(rst), .wr_fire(accept), .swap(swap_evt),
    .row_idx(fill_row), .full(fill_full)
  );

  tpose_drain_ctrl #(.COLS(PIX)) u_drain (
    .clk(clk), .rst(rst), .swap(swap_evt),
    .active(drain_active), .col_idx(drain_col), .last(drain_last)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    tpose_bank #(.W(WORD_W), .ROWS(OUT_PORTS), .COLS(PIX)) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(accept && (fill_sel == bank_e'(b))),
      .wr_row(fill_row), .wr_data(in_data), .wr_mask(in_mask),
      .rd_col(drain_col), .rd_data(bank_rd[b])
    );
  end

  assign col_valid    = drain_active;
  assign col_data     = bank_rd[drain_sel];
  assign stencil_done = drain_last;
endmodule

// File: rtl/tpose_checks.sv
module tpose_checks #(
  parameter int ROWS = 4,
  localparam int RW = tpose_pkg::idx_width(ROWS)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          col_valid,
  input logic          stencil_done,
  input logic          accept,
  input logic          swap_evt,
  input logic [RW-1:0] fill_row
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (in_ready && !col_valid && !stencil_done)); // R1
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (rst) (accept && fill_row == LAST_ROW) |=> !in_ready); // R4
  AST_STALL_HOLDS_ROW: assert property (@(posedge clk) disable iff (rst) (in_valid && !in_ready) |=> (fill_row == $past(fill_row))); // R4
  AST_SWAP_DRAINS: assert property (@(posedge clk) disable iff (rst) swap_evt |=> col_valid); // R5
  AST_DRAIN_UNBROKEN: assert property (@(posedge clk) disable iff (rst) (col_valid && !stencil_done) |=> col_valid); // R6
  AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (rst) (stencil_done && !swap_evt) |=> !col_valid); // R6
  AST_DONE_WITH_COL: assert property (@(posedge clk) disable iff (rst) stencil_done |-> col_valid); // R7
  AST_SWAP_FREES: assert property (@(posedge clk) disable iff (rst) swap_evt |=> in_ready); // R8
endmodule

bind transpose_buffer tpose_checks #(.ROWS(OUT_PORTS)) u_checks (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .col_valid(col_valid), .stencil_done(stencil_done),
  .accept(accept), .swap_evt(swap_evt), .fill_row(fill_row)
);

// File: tb/tb_transpose_buffer.sv
module tb_transpose_buffer;
  localparam int W = 8, MW = 64, OP = 4, P = MW / W;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic in_valid = 1'b0;
  logic [MW-1:0] in_data = '0;
  logic [P-1:0] in_mask = '0;
  logic in_ready, col_valid, stencil_done;
  logic [OP*W-1:0] col_data;

  transpose_buffer #(.WORD_W(W), .MEM_W(MW), .OUT_PORTS(OP)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mask(in_mask), .col_valid(col_valid),
    .col_data(col_data), .stencil_done(stencil_done)
  );

  int checks = 0, errors = 0;
  logic [W-1:0] mdl [2][OP][P];
  int mdl_sel = 0;
  logic [OP*W-1:0] exp_q [$];
  string tag_q [$];
  int grp_cnt = 0;
  bit prev_valid = 0;
  bit s_ready, s_valid, s_done;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: sample and monitor at the falling edge, then pass the rising edge.
  task automatic step();
    @(negedge clk);
    s_ready = in_ready; s_valid = col_valid; s_done = stencil_done;
    if (!rst) begin
      if (col_valid) begin
        if (exp_q.size() == 0) chk(0, "R5", "unexpected column", col_data, 0);
        else begin
          logic [OP*W-1:0] e = exp_q.pop_front();
          string t = tag_q.pop_front();
          chk(col_data == e, t, "column data", col_data, e);
        end
        chk(stencil_done == (grp_cnt == P-1), "R7", "done pulse", stencil_done, grp_cnt == P-1);
        if (!prev_valid && grp_cnt != 0) chk(0, "R6", "drain interrupted", grp_cnt, 0);
        grp_cnt = (grp_cnt == P-1) ? 0 : grp_cnt + 1;
      end else if (stencil_done) chk(0, "R7", "done without column", 1, 0);
      prev_valid = col_valid;
    end
    @(posedge clk); #1;
  endtask

  function automatic logic [MW-1:0] mk_row(int seed, int r);
    logic [MW-1:0] v;
    for (int j = 0; j < P; j++) v[j*W +: W] = 8'(seed * 37 + r * 16 + j + 1);
    return v;
  endfunction

  task automatic fill(int seed, logic [P-1:0] masks [OP], string tag);
    for (int r = 0; r < OP; r++) begin
      in_valid = 1'b1; in_data = mk_row(seed, r); in_mask = masks[r];
      do step(); while (!s_ready);
      for (int j = 0; j < P; j++)
        if (masks[r][j]) mdl[mdl_sel][r][j] = in_data[j*W +: W];
    end
    in_valid = 1'b0;
    for (int j = 0; j < P; j++) begin
      logic [OP*W-1:0] c;
      for (int k = 0; k < OP; k++) c[k*W +: W] = mdl[mdl_sel][k][j];
      exp_q.push_back(c); tag_q.push_back(tag);
    end
    mdl_sel = 1 - mdl_sel;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
    exp_q.delete(); tag_q.delete();
    grp_cnt = 0; prev_valid = 0; mdl_sel = 0;
    for (int b = 0; b < 2; b++) for (int r = 0; r < OP; r++) for (int j = 0; j < P; j++) mdl[b][r][j] = '0;
  endtask

  task automatic wait_idle(string tag);
    for (int i = 0; i < 100 && (exp_q.size() != 0 || col_valid); i++) step();
    step();
    chk(exp_q.size() == 0, tag, "columns left undelivered", exp_q.size(), 0);
    chk(!s_valid, tag, "valid after drain", s_valid, 0);
  endtask

  task automatic t_reset();
    do_reset(); step();
    chk(s_ready, "R1", "in_ready after reset", s_ready, 1);
    chk(!s_valid, "R1", "col_valid after reset", s_valid, 0);
    chk(!s_done, "R1", "stencil_done after reset", s_done, 0);
  endtask

  task automatic t_basic();
    logic [P-1:0] m [OP] = '{default: '1};
    fill(1, m, "R2");
    step();
    chk(!s_ready, "R4", "ready after last row", s_ready, 0);
    chk(!s_valid, "R5", "valid before swap", s_valid, 0);
    step();
    chk(s_valid, "R5", "valid one cycle after swap", s_valid, 1);
    chk(s_ready, "R8", "ready after swap", s_ready, 1);
    wait_idle("R6");
  endtask

  task automatic t_back_to_back();
    logic [P-1:0] m [OP] = '{default: '1};
    fill(2, m, "R2");
    fill(3, m, "R2");
    chk(s_valid, "R8", "second bank filled while first drains", s_valid, 1);
    in_valid = 1'b1; in_data = '1; in_mask = '1;
    for (int i = 0; i < 2; i++) begin
      step();
      chk(!s_ready, "R4", "stall while both banks busy", s_ready, 0);
    end
    in_valid = 1'b0;
    fill(4, m, "R4");
    wait_idle("R6");
  endtask

  task automatic t_mask();
    logic [P-1:0] m [OP] = '{8'hA5, 8'h0F, 8'h00, 8'hF0};
    fill(5, m, "R3");
    wait_idle("R3");
    m = '{8'h5A, 8'h81, 8'hFF, 8'h3C};
    fill(6, m, "R3");
    wait_idle("R3");
  endtask

  task automatic t_mid_reset();
    logic [P-1:0] m [OP] = '{default: '1};
    fill(7, m, "R2");
    step(); step(); step();
    chk(s_valid, "R9", "drain in progress before reset", s_valid, 1);
    do_reset(); step();
    chk(s_ready && !s_valid, "R9", "idle after mid-drain reset", {s_ready, s_valid}, 2'b10);
    m = '{8'h0F, 8'hF0, 8'h33, 8'hCC};
    fill(8, m, "R9");
    wait_idle("R9");
  endtask

  bit finished = 0;
  initial begin
    t_reset();
    t_basic();
    t_back_to_back();
    t_mask();
    t_mid_reset();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule